// File: doc/BRIEF.md
# Subchannel Method Dispatcher with Idle Barriers

This block sits between a command decoder and a set of execution engines. Each decoded method write carries a subchannel number, a method address and a data word. Engine methods go to the engine port picked by the subchannel. Host methods are handled inside the block and never reach an engine port.

The block keeps track of which engine subchannel is active. When an engine method names a different subchannel, the block holds that write back until every engine reports idle. It then forwards the write and makes the new subchannel the active one. Two host methods also stall the input stream:

- An explicit wait-for-idle method stalls until all engines are idle.
- A semaphore-acquire method polls a memory word through a read port until the word equals a programmed payload.

A cycle counter reports the time spent stalled. A one-cycle pulse marks each barrier caused by a subchannel change.

Top module: `subch_dispatch`

## Requirements
- R1: An engine method (address 0x040 or higher) accepted on subchannel s without a barrier appears on engine port s in the next cycle. Exactly one bit of `eng_valid` (bit s) is high, and `eng_mthd`/`eng_data` carry the accepted address and data.
- R2: After reset no subchannel is active. The first engine method is forwarded without a barrier, even when the engines are busy.
- R3: Engine methods on the same subchannel as the active one are forwarded back to back with no stall, whatever the state of `eng_idle`.
- R4: An engine method on a subchannel other than the active one raises `switch_pulse` for exactly one cycle and drops `in_ready`. It is not forwarded while any bit of `eng_idle` is low. One cycle after all bits are high it is forwarded and its subchannel becomes the active one.
- R5: A host method (address below 0x040) on any subchannel causes no barrier and leaves the active subchannel unchanged.
- R6: Host method 0x01C (wait-for-idle) drops `in_ready` until a cycle in which every bit of `eng_idle` is high. `in_ready` rises in the next cycle.
- R7: Host method 0x004 sets the semaphore address and 0x008 sets the payload. Host method 0x00C raises `sem_rd_req` with `sem_rd_addr` equal to that address and holds it until `sem_rd_ack`.
  - If the acknowledged data differs from the payload, the request stays low for exactly RETRY_GAP cycles and is then raised again.
  - If the data matches, `in_ready` returns high in the next cycle.
- R8: `stall_cycles` is zero after reset and increases by one for every cycle in which `in_ready` is low.
- R9: A host method other than 0x004, 0x008, 0x00C and 0x01C is accepted and has no effect on the engine ports, on `switch_pulse` or on `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A method write is offered |
| in_ready | output | 1 | Block accepts a write this cycle |
| in_subch | input | SUBCH_W | Subchannel of the offered write |
| in_mthd | input | MTHD_W | Method address |
| in_data | input | DATA_W | Method data |
| eng_valid | output | NUM_ENG | One-hot write strobe per engine port |
| eng_mthd | output | MTHD_W | Method address to engines |
| eng_data | output | DATA_W | Method data to engines |
| eng_idle | input | NUM_ENG | Idle flag from each engine |
| sem_rd_req | output | 1 | Semaphore read request |
| sem_rd_addr | output | DATA_W | Semaphore word address |
| sem_rd_ack | input | 1 | Read data valid |
| sem_rd_data | input | DATA_W | Read data |
| stall_cycles | output | CNT_W | Cycles spent stalled |
| switch_pulse | output | 1 | One-cycle flag for each subchannel-change barrier |

## Verification
The hardest state to reach is a barrier that must stay closed while only some engines have gone idle. The stimulus first sets up an active subchannel with all engines busy and then offers a write on another subchannel. It releases `eng_idle` in two steps, all engines but one and then the last, and checks that nothing is forwarded until the last step.

Host-method exemption is probed in a second way. A host write is sent on a foreign subchannel, and then an engine write on the original subchannel must go through at once with the engines still busy. The semaphore loop is driven by a memory model that answers with mismatching words twice before matching. This exposes the exact retry gap and the read count.

// File: rtl/subch_dispatch_pkg.sv
package subch_dispatch_pkg;

  // Method addresses below this limit are handled inside the block.
  localparam int unsigned HOST_LIMIT = 'h040;
  localparam int unsigned M_SEM_ADDR = 'h004;
  localparam int unsigned M_SEM_PAY  = 'h008;
  localparam int unsigned M_SEM_ACQ  = 'h00C;
  localparam int unsigned M_WFI      = 'h01C;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_WFI   = 2'd2,
    ST_SEM   = 2'd3
  } disp_state_e;

  typedef enum logic [2:0] {
    HOP_NONE = 3'd0,
    HOP_ADDR = 3'd1,
    HOP_PAY  = 3'd2,
    HOP_ACQ  = 3'd3,
    HOP_WFI  = 3'd4
  } host_op_e;

endpackage

// File: rtl/sd_classify.sv
module sd_classify
  import subch_dispatch_pkg::*;
#(
  parameter int MTHD_W  = 12,
  parameter int SUBCH_W = 3
) (
  input  logic [MTHD_W-1:0]  mthd,
  input  logic [SUBCH_W-1:0] subch,
  input  logic               cur_valid,
  input  logic [SUBCH_W-1:0] cur_subch,
  output logic               is_host,
  output logic               is_switch,
  output host_op_e           hop
);

  always_comb begin
    is_host   = (mthd < MTHD_W'(HOST_LIMIT));
    is_switch = !is_host && cur_valid && (subch != cur_subch);
    if (mthd == MTHD_W'(M_SEM_ADDR))      hop = HOP_ADDR;
    else if (mthd == MTHD_W'(M_SEM_PAY))  hop = HOP_PAY;
    else if (mthd == MTHD_W'(M_SEM_ACQ))  hop = HOP_ACQ;
    else if (mthd == MTHD_W'(M_WFI))      hop = HOP_WFI;
    else                                  hop = HOP_NONE;
  end

endmodule

// File: rtl/sd_route.sv
module sd_route #(
  parameter int NUM_ENG = 8,
  parameter int MTHD_W  = 12,
  parameter int DATA_W  = 32,
  localparam int SUBCH_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [SUBCH_W-1:0] subch,
  input  logic [MTHD_W-1:0]  mthd,
  input  logic [DATA_W-1:0]  data,
  output logic [NUM_ENG-1:0] eng_valid,
  output logic [MTHD_W-1:0]  eng_mthd,
  output logic [DATA_W-1:0]  eng_data
);

  for (genvar i = 0; i < NUM_ENG; i++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eng_valid[i] <= 1'b0;
      else        eng_valid[i] <= fire && (subch == SUBCH_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_mthd <= '0;
      eng_data <= '0;
    end else if (fire) begin
      eng_mthd <= mthd;
      eng_data <= data;
    end
  end

endmodule

// File: rtl/sd_sem_poll.sv
module sd_sem_poll #(
  parameter int DATA_W    = 32,
  parameter int RETRY_GAP = 4,
  localparam int GAP_W = $clog2(RETRY_GAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] payload,
  output logic              rd_req,
  output logic [DATA_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done
);

  logic             wait_q, wait_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             match;

  assign rd_req  = active && !wait_q;
  assign rd_addr = addr;
  assign match   = (rd_data == payload);
  assign done    = rd_req && rd_ack && match;

  always_comb begin
    wait_d = wait_q;
    cnt_d  = cnt_q;
    if (!active) begin
      wait_d = 1'b0;
      cnt_d  = '0;
    end else if (wait_q) begin
      if (cnt_q == '0) wait_d = 1'b0;
      else             cnt_d  = cnt_q - GAP_W'(1);
    end else if (rd_ack && !match) begin
      wait_d = 1'b1;
      cnt_d  = GAP_W'(RETRY_GAP - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/subch_dispatch.sv
module subch_dispatch
  import subch_dispatch_pkg::*;
#(
  parameter int NUM_ENG   = 8,
  parameter int MTHD_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int RETRY_GAP = 4,
  localparam int SUBCH_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SUBCH_W-1:0] in_subch,
  input  logic [MTHD_W-1:0]  in_mthd,
  input  logic [DATA_W-1:0]  in_data,
  output logic [NUM_ENG-1:0] eng_valid,
  output logic [MTHD_W-1:0]  eng_mthd,
  output logic [DATA_W-1:0]  eng_data,
  input  logic [NUM_ENG-1:0] eng_idle,
  output logic               sem_rd_req,
  output logic [DATA_W-1:0]  sem_rd_addr,
  input  logic               sem_rd_ack,
  input  logic [DATA_W-1:0]  sem_rd_data,
  output logic [CNT_W-1:0]   stall_cycles,
  output logic               switch_pulse
);

  disp_state_e        state_q, state_d;
  logic               cur_valid_q, cur_valid_d;
  logic [SUBCH_W-1:0] cur_subch_q, cur_subch_d;
  logic [SUBCH_W-1:0] pend_subch_q;
  logic [MTHD_W-1:0]  pend_mthd_q;
  logic [DATA_W-1:0]  pend_data_q;
  logic [DATA_W-1:0]  sem_addr_q, sem_pay_q;
  logic [CNT_W-1:0]   stall_q;
  logic               pulse_q, pulse_d;

  logic               accept, all_idle, sem_done;
  logic               is_host, is_switch;
  host_op_e           hop;
  logic               capture, addr_we, pay_we;
  logic               fire;
  logic [SUBCH_W-1:0] fire_subch;
  logic [MTHD_W-1:0]  fire_mthd;
  logic [DATA_W-1:0]  fire_data;

  assign in_ready     = (state_q == ST_RUN);
  assign accept       = in_valid && in_ready;
  assign all_idle     = &eng_idle;
  assign stall_cycles = stall_q;
  assign switch_pulse = pulse_q;

  sd_classify #(.MTHD_W(MTHD_W), .SUBCH_W(SUBCH_W)) u_cls (
    .mthd(in_mthd), .subch(in_subch), .cur_valid(cur_valid_q),
    .cur_subch(cur_subch_q), .is_host(is_host), .is_switch(is_switch), .hop(hop)
  );

  always_comb begin
    state_d     = state_q;
    cur_valid_d = cur_valid_q;
    cur_subch_d = cur_subch_q;
    pulse_d     = 1'b0;
    capture     = 1'b0;
    addr_we     = 1'b0;
    pay_we      = 1'b0;
    fire        = 1'b0;
    fire_subch  = in_subch;
    fire_mthd   = in_mthd;
    fire_data   = in_data;
    case (state_q)
      ST_RUN: begin
        if (accept) begin
          if (is_host) begin
            case (hop)
              HOP_ADDR: addr_we = 1'b1;
              HOP_PAY:  pay_we  = 1'b1;
              HOP_WFI:  state_d = ST_WFI;
              HOP_ACQ:  state_d = ST_SEM;
              default:  ;
            endcase
          end else if (is_switch) begin
            capture = 1'b1;
            pulse_d = 1'b1;
            state_d = ST_DRAIN;
          end else begin
            fire        = 1'b1;
            cur_valid_d = 1'b1;
            cur_subch_d = in_subch;
          end
        end
      end
      ST_DRAIN: begin
        if (all_idle) begin
          fire        = 1'b1;
          fire_subch  = pend_subch_q;
          fire_mthd   = pend_mthd_q;
          fire_data   = pend_data_q;
          cur_valid_d = 1'b1;
          cur_subch_d = pend_subch_q;
          state_d     = ST_RUN;
        end
      end
      ST_WFI: if (all_idle) state_d = ST_RUN;
      ST_SEM: if (sem_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      cur_valid_q <= 1'b0;
      cur_subch_q <= '0;
      pulse_q     <= 1'b0;
      stall_q     <= '0;
    end else begin
      state_q     <= state_d;
      cur_valid_q <= cur_valid_d;
      cur_subch_q <= cur_subch_d;
      pulse_q     <= pulse_d;
      if (!in_ready) stall_q <= stall_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_subch_q <= '0;
      pend_mthd_q  <= '0;
      pend_data_q  <= '0;
    end else if (capture) begin
      pend_subch_q <= in_subch;
      pend_mthd_q  <= in_mthd;
      pend_data_q  <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sem_addr_q <= '0;
      sem_pay_q  <= '0;
    end else begin
      if (addr_we) sem_addr_q <= in_data;
      if (pay_we)  sem_pay_q  <= in_data;
    end
  end

  sd_sem_poll #(.DATA_W(DATA_W), .RETRY_GAP(RETRY_GAP)) u_sem (
    .clk(clk), .rst_n(rst_n), .active(state_q == ST_SEM),
    .addr(sem_addr_q), .payload(sem_pay_q),
    .rd_req(sem_rd_req), .rd_addr(sem_rd_addr),
    .rd_ack(sem_rd_ack), .rd_data(sem_rd_data), .done(sem_done)
  );

  sd_route #(.NUM_ENG(NUM_ENG), .MTHD_W(MTHD_W), .DATA_W(DATA_W)) u_route (
    .clk(clk), .rst_n(rst_n), .fire(fire), .subch(fire_subch),
    .mthd(fire_mthd), .data(fire_data),
    .eng_valid(eng_valid), .eng_mthd(eng_mthd), .eng_data(eng_data)
  );

endmodule

// File: rtl/subch_dispatch_chk.sv
module subch_dispatch_chk #(
  parameter int NUM_ENG = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic [NUM_ENG-1:0] eng_valid,
  input logic               sem_rd_req,
  input logic [DATA_W-1:0]  sem_rd_addr,
  input logic               sem_rd_ack,
  input logic [CNT_W-1:0]   stall_cycles,
  input logic               switch_pulse
);

  p_one_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid));

  p_switch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (!in_ready && eng_valid == '0));

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse);

  p_sem_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_rd_req && !sem_rd_ack) |=> (sem_rd_req && $stable(sem_rd_addr)));

  p_sem_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sem_rd_req |-> !in_ready);

  p_stall_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (stall_cycles == $past(stall_cycles) + CNT_W'(1)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $stable(stall_cycles));

endmodule

bind subch_dispatch subch_dispatch_chk #(
  .NUM_ENG(NUM_ENG), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .eng_valid(eng_valid),
  .sem_rd_req(sem_rd_req), .sem_rd_addr(sem_rd_addr), .sem_rd_ack(sem_rd_ack),
  .stall_cycles(stall_cycles), .switch_pulse(switch_pulse)
);

// File: tb/subch_dispatch_bench.sv
module subch_dispatch_bench;

  localparam int NUM_ENG   = 8;
  localparam int MTHD_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 32;
  localparam int RETRY_GAP = 4;
  localparam int SUBCH_W   = 3;
  localparam logic [31:0] SEM_ADDR = 32'h0000_1000;
  localparam logic [31:0] SEM_PAY  = 32'hCAFE_0001;

  typedef struct {
    int          port;
    int          mthd;
    logic [31:0] data;
  } item_t;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic               in_ready;
  logic [SUBCH_W-1:0] in_subch;
  logic [MTHD_W-1:0]  in_mthd;
  logic [DATA_W-1:0]  in_data;
  logic [NUM_ENG-1:0] eng_valid;
  logic [MTHD_W-1:0]  eng_mthd;
  logic [DATA_W-1:0]  eng_data;
  logic [NUM_ENG-1:0] eng_idle;
  logic               sem_rd_req;
  logic [DATA_W-1:0]  sem_rd_addr;
  logic               sem_rd_ack;
  logic [DATA_W-1:0]  sem_rd_data;
  logic [CNT_W-1:0]   stall_cycles;
  logic               switch_pulse;

  int checks = 0;
  int fails  = 0;
  int out_cnt = 0;
  int pulse_cnt = 0;
  int stall_ref = 0;
  int sem_reads = 0;
  int gap_run = 0;
  item_t exp_q[$];

  always #5 clk = ~clk;

  subch_dispatch #(
    .NUM_ENG(NUM_ENG), .MTHD_W(MTHD_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .RETRY_GAP(RETRY_GAP)
  ) u_subch_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_subch(in_subch), .in_mthd(in_mthd), .in_data(in_data),
    .eng_valid(eng_valid), .eng_mthd(eng_mthd), .eng_data(eng_data),
    .eng_idle(eng_idle), .sem_rd_req(sem_rd_req), .sem_rd_addr(sem_rd_addr),
    .sem_rd_ack(sem_rd_ack), .sem_rd_data(sem_rd_data),
    .stall_cycles(stall_cycles), .switch_pulse(switch_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int sc, input int m, input logic [31:0] d, input bit expect_out);
    @(negedge clk);
    in_valid = 1'b1;
    in_subch = SUBCH_W'(sc);
    in_mthd  = MTHD_W'(m);
    in_data  = d;
    if (expect_out) exp_q.push_back('{port: sc, mthd: m, data: d});
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor, scoreboard and memory model, all away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(stall_cycles == CNT_W'(stall_ref), "R8", "stall counter", stall_cycles, stall_ref);
      if (!in_ready) stall_ref++;
      if (switch_pulse) pulse_cnt++;
      if (eng_valid != '0) begin
        int port;
        port = -1;
        out_cnt++;
        for (int i = 0; i < NUM_ENG; i++) if (eng_valid[i]) port = i;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected engine write", eng_valid, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(port == e.port, "R1", "engine port", port, e.port);
          chk(eng_mthd == MTHD_W'(e.mthd), "R1", "method", eng_mthd, e.mthd);
          chk(eng_data == e.data, "R1", "data", eng_data, e.data);
        end
      end
      if (sem_rd_req) begin
        chk(sem_rd_addr == SEM_ADDR, "R7", "semaphore address", sem_rd_addr, SEM_ADDR);
        if (sem_reads > 0)
          chk(gap_run == RETRY_GAP, "R7", "retry gap", gap_run, RETRY_GAP);
        sem_reads++;
        gap_run     = 0;
        sem_rd_ack  = 1'b1;
        sem_rd_data = (sem_reads >= 3) ? SEM_PAY : 32'(sem_reads);
      end else begin
        gap_run++;
        sem_rd_ack  = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int base;
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_subch    = '0;
    in_mthd     = '0;
    in_data     = '0;
    eng_idle    = '1;
    sem_rd_ack  = 1'b0;
    sem_rd_data = '0;
    repeat (3) @(negedge clk);
    chk(eng_valid == '0, "R1", "reset eng_valid", eng_valid, 0);
    chk(stall_cycles == '0, "R8", "reset stall", stall_cycles, 0);
    chk(in_ready == 1'b1, "R8", "reset in_ready", in_ready, 1);
    chk(switch_pulse == 1'b0, "R4", "reset pulse", switch_pulse, 0);
    #1 rst_n = 1'b1;

    // R2: first engine method with busy engines goes straight through
    eng_idle = '0;
    send(2, 'h100, 32'hA000_0001, 1);
    repeat (2) @(negedge clk);
    chk(out_cnt == 1, "R2", "first write forwarded", out_cnt, 1);
    chk(pulse_cnt == 0, "R2", "no barrier on first", pulse_cnt, 0);

    // R3: same subchannel back to back, engines busy
    send(2, 'h104, 32'hA000_0002, 1);
    send(2, 'h108, 32'hA000_0003, 1);
    repeat (2) @(negedge clk);
    chk(out_cnt == 3, "R3", "same-subch writes", out_cnt, 3);
    chk(stall_ref == 0, "R3", "no stall on same subch", stall_ref, 0);

    // R4: switch to subchannel 6 waits for every engine
    send(6, 'h200, 32'hB000_0001, 1);
    repeat (6) @(negedge clk);
    chk(out_cnt == 3, "R4", "held while busy", out_cnt, 3);
    chk(in_ready == 1'b0, "R4", "in_ready low in barrier", in_ready, 0);
    chk(pulse_cnt == 1, "R4", "switch pulse", pulse_cnt, 1);
    eng_idle = 8'b1111_1110;
    repeat (4) @(negedge clk);
    chk(out_cnt == 3, "R4", "held while one engine busy", out_cnt, 3);
    eng_idle = '1;
    repeat (2) @(negedge clk);
    chk(out_cnt == 4, "R4", "forwarded after idle", out_cnt, 4);
    chk(in_ready == 1'b1, "R4", "ready after barrier", in_ready, 1);
    chk(pulse_cnt == 1, "R4", "single pulse", pulse_cnt, 1);

    // R9 and R5: host methods on foreign subchannels
    eng_idle = '0;
    base = stall_ref;
    send(1, 'h030, 32'h1234_5678, 0);
    repeat (2) @(negedge clk);
    chk(out_cnt == 4, "R9", "unknown host method no output", out_cnt, 4);
    chk(in_ready == 1'b1, "R9", "unknown host method no stall", in_ready, 1);
    chk(stall_ref == base, "R9", "no stall cycles", stall_ref, base);
    send(4, 'h004, SEM_ADDR, 0);
    send(5, 'h008, SEM_PAY, 0);
    send(6, 'h204, 32'hB000_0002, 1);
    repeat (2) @(negedge clk);
    chk(out_cnt == 5, "R5", "active subch kept after host", out_cnt, 5);
    chk(pulse_cnt == 1, "R5", "host methods no switch", pulse_cnt, 1);

    // R6: explicit wait-for-idle
    eng_idle = 8'h7F;
    send(0, 'h01C, 32'h0, 0);
    repeat (5) @(negedge clk);
    chk(in_ready == 1'b0, "R6", "stalled while busy", in_ready, 0);
    chk(out_cnt == 5, "R6", "no output on wfi", out_cnt, 5);
    eng_idle = '1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R6", "resumes after idle", in_ready, 1);

    // R7: semaphore acquire, matches on the third read
    send(1, 'h00C, 32'h0, 0);
    for (int i = 0; i < 200 && !in_ready; i++) @(negedge clk);
    chk(in_ready == 1'b1, "R7", "acquire completes", in_ready, 1);
    chk(sem_reads == 3, "R7", "read count", sem_reads, 3);
    chk(pulse_cnt == 1, "R7", "no switch on acquire", pulse_cnt, 1);

    // R1/R4: switches with idle engines across other ports
    send(0, 'h300, 32'hC000_0000, 1);
    send(7, 'h3FC, 32'hC000_0007, 1);
    send(7, 'h040, 32'hC000_0008, 1);
    repeat (4) @(negedge clk);
    chk(out_cnt == 8, "R1", "all routed", out_cnt, 8);
    chk(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);
    chk(pulse_cnt == 3, "R4", "two more switches", pulse_cnt, 3);
    finish_run();
  end

endmodule